// File: doc/BRIEF.md
# UART Register and Interrupt Front End

This block is the software-visible side of a simple serial port. It sits on a 32-bit register bus that only does whole-word accesses and exposes five word registers. It turns a write to the data register into one byte on a transmit stream. It captures bytes from a receive stream into the data register. It raises sticky event flags for both directions and combines them with per-direction enables into one interrupt line. The serial bit engine is not part of this block: transmit and receive are plain byte streams with valid/ready handshakes.

Software sets the enables in the control register and reads the status register to find out which events fired. It acknowledges an event by writing a one to that event's bit. While a received byte has not been acknowledged, the receive stream is back-pressured. The clock-divisor and debug words are storage only: the serial engine or the rest of the chip may use them. Bus reads return data one cycle after the request.

Top module: `serial_front_ctl`

## Requirements
- R1: After reset, status reads 0x1, the data, divisor, control and debug registers read 0, `irq`, `tx_valid` and `bus_err` are low, and `rx_ready` is high.
- R2: The word index is `bus_addr >> 2`, and address bits 1:0 are ignored. Index 0 is data, 1 is divisor, 2 is status, 3 is control and 4 is debug.
- R3: Divisor, control and debug keep the full 32-bit written value and read it back unchanged. Control bit 2 and all debug bits are stored and have no other effect.
- R4: A data write puts bits 7:0 on `tx_data` with `tx_valid` high from the next cycle. `tx_valid` stays high with the byte stable until a cycle with `tx_ready` high. A further data write while a byte is pending replaces that byte. Every data write sets the transmit event, which is status bit 2.
- R5: `rx_ready` is high exactly when the receive event (status bit 1) is clear. On a clock edge with `rx_valid` and `rx_ready` both high, the byte is stored and the receive event is set. A data-register read then returns that byte in bits 7:0, with the upper bits zero.
- R6: While the receive event is set, an offered byte is refused, and the data register keeps the earlier byte.
- R7: A status write clears bit 1 and/or bit 2 wherever the written value has a one. Zero bits leave the flags unchanged. Status bit 0 always reads 1.
- R8: If a receive capture and a status write clearing bit 1 happen in the same cycle, the receive event ends up set.
- R9: `irq` is a register equal to (control bit 0 AND status bit 1) OR (control bit 1 AND status bit 2), evaluated from the flag and control values of the previous cycle.
- R10: `bus_rdata` is loaded on the edge where `bus_rd` is high and holds its value until the next read. A read in the same cycle as a write returns the value from before the write.
- R11: An access to word index 5 or above reads 0 and changes no register. It also raises `bus_err` for exactly one cycle, the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| bus_err | output | 1 | One-cycle pulse after an access to an unimplemented word |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Transmit sink accepts the byte |
| tx_data | output | BYTE_W | Transmit byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_ready | output | 1 | Receive byte can be taken |
| rx_data | input | BYTE_W | Receive byte |
| irq | output | 1 | Interrupt request, registered |

## Verification
The bench uses the default parameters: ADDR_W = 8, DATA_W = 32 and BYTE_W = 8. The 8-bit byte address gives 64 word indexes, so the 59 unimplemented words beyond the debug register can be reached alongside all five real ones, with nonzero low address bits mixed in. Full 32-bit random values go into the stored words, so upper-bit corruption would show up. Directed cases cover transmit back-pressure with a replacing write, a byte refused while the receive flag is set, and a receive capture that collides with a clearing status write.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  // word indexes (order is the register map)
  localparam int IDX_DATA  = 0;
  localparam int IDX_DIV   = 1;
  localparam int IDX_STAT  = 2;
  localparam int IDX_CTRL  = 3;
  localparam int IDX_DBG   = 4;
  localparam int NUM_WORDS = 5;

  // status bit positions
  localparam int ST_THRE = 0;
  localparam int ST_RXEV = 1;
  localparam int ST_TXEV = 2;

  // control bit positions
  localparam int CT_RXIE = 0;
  localparam int CT_TXIE = 1;

  // stored-only words: slot order inside the config bank
  localparam int CFG_DIV  = 0;
  localparam int CFG_CTRL = 1;
  localparam int CFG_DBG  = 2;
  localparam int NUM_CFG  = 3;
endpackage

// File: rtl/sfe_decode.sv
module sfe_decode
  import sfe_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [IDX_W-1:0]     widx,
  output logic [NUM_WORDS-1:0] wr_sel,
  output logic                 hit,
  output logic                 err
);
  assign hit = (widx < IDX_W'(NUM_WORDS));

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_sel
    assign wr_sel[i] = bus_wr && (widx == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= (bus_wr || bus_rd) && !hit;
  end

  // at most one register is written per cycle
  assert_onehot_sel_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));
endmodule

// File: rtl/sfe_cfg_regs.sv
module sfe_cfg_regs #(
  parameter int DATA_W = 32,
  parameter int N      = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N-1:0]               we,
  input  logic [DATA_W-1:0]          wdata,
  output logic [N-1:0][DATA_W-1:0]   q
);
  for (genvar i = 0; i < N; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)       q[i] <= '0;
      else if (we[i]) q[i] <= wdata;
    end

    // an unwritten word keeps its value (R3)
    assert_cfg_keep_R3: assert property (@(posedge clk) disable iff (rst)
      !we[i] |=> $stable(q[i]));
  end
endmodule

// File: rtl/sfe_events.sv
module sfe_events #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_we,
  input  logic              stat_we,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              clr_rx,
  input  logic              clr_tx,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              rx_ie,
  input  logic              tx_ie,
  output logic              rx_evt,
  output logic              tx_evt,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              irq
);
  logic rx_take;

  assign rx_ready = !rx_evt;
  assign rx_take  = rx_valid && !rx_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_evt  <= 1'b0;
      tx_evt  <= 1'b0;
      rx_byte <= '0;
    end else begin
      // a new event outranks a same-cycle clear
      if (rx_take)               rx_evt <= 1'b1;
      else if (stat_we && clr_rx) rx_evt <= 1'b0;
      if (data_we)               tx_evt <= 1'b1;
      else if (stat_we && clr_tx) tx_evt <= 1'b0;
      if (rx_take)               rx_byte <= rx_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (data_we) begin
      tx_valid <= 1'b1;
      tx_data  <= wbyte;
    end else if (tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (rx_ie && rx_evt) || (tx_ie && tx_evt);
  end

  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready && !data_we |=> tx_valid && $stable(tx_data));
  assert_tx_evt_R4: assert property (@(posedge clk) disable iff (rst)
    data_we |=> tx_evt);
  assert_rx_capture_R5: assert property (@(posedge clk) disable iff (rst)
    rx_valid && rx_ready |=> rx_evt && (rx_byte == $past(rx_data)));
  assert_rx_hold_R6: assert property (@(posedge clk) disable iff (rst)
    rx_evt |=> $stable(rx_byte));
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    rx_valid && rx_ready && stat_we && clr_rx |=> rx_evt);
endmodule

// File: rtl/serial_front_ctl.sv
module serial_front_ctl
  import sfe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]                widx;
  logic [NUM_WORDS-1:0]            wr_sel;
  logic                            hit;
  logic [NUM_CFG-1:0]              cfg_we;
  logic [NUM_CFG-1:0][DATA_W-1:0]  cfg_q;
  logic                            rx_evt, tx_evt;
  logic [BYTE_W-1:0]               rx_byte;
  logic [DATA_W-1:0]               rd_mux;
  logic                            unused_lsb;

  assign widx       = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];

  sfe_decode #(.IDX_W(IDX_W)) u_decode (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .widx(widx), .wr_sel(wr_sel), .hit(hit), .err(bus_err)
  );

  assign cfg_we[CFG_DIV]  = wr_sel[IDX_DIV];
  assign cfg_we[CFG_CTRL] = wr_sel[IDX_CTRL];
  assign cfg_we[CFG_DBG]  = wr_sel[IDX_DBG];

  sfe_cfg_regs #(.DATA_W(DATA_W), .N(NUM_CFG)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(bus_wdata), .q(cfg_q)
  );

  sfe_events #(.BYTE_W(BYTE_W)) u_events (
    .clk(clk), .rst(rst),
    .data_we(wr_sel[IDX_DATA]), .stat_we(wr_sel[IDX_STAT]),
    .wbyte(bus_wdata[BYTE_W-1:0]),
    .clr_rx(bus_wdata[ST_RXEV]), .clr_tx(bus_wdata[ST_TXEV]),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_ie(cfg_q[CFG_CTRL][CT_RXIE]), .tx_ie(cfg_q[CFG_CTRL][CT_TXIE]),
    .rx_evt(rx_evt), .tx_evt(tx_evt), .rx_byte(rx_byte), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    case (widx)
      IDX_W'(IDX_DATA): rd_mux = DATA_W'(rx_byte);
      IDX_W'(IDX_DIV):  rd_mux = cfg_q[CFG_DIV];
      IDX_W'(IDX_STAT): begin
        rd_mux[ST_THRE] = 1'b1;
        rd_mux[ST_RXEV] = rx_evt;
        rd_mux[ST_TXEV] = tx_evt;
      end
      IDX_W'(IDX_CTRL): rd_mux = cfg_q[CFG_CTRL];
      IDX_W'(IDX_DBG):  rd_mux = cfg_q[CFG_DBG];
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= hit ? rd_mux : '0;
  end

  assert_thre_R7: assert property (@(posedge clk) disable iff (rst)
    bus_rd && (widx == IDX_W'(IDX_STAT)) |=> bus_rdata[ST_THRE]);
  assert_rd_unimpl_R11: assert property (@(posedge clk) disable iff (rst)
    bus_rd && !hit |=> (bus_rdata == '0) && bus_err);
  assert_irq_rx_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_q[CFG_CTRL][CT_RXIE] && rx_evt |=> irq);
  assert_irq_low_R9: assert property (@(posedge clk) disable iff (rst)
    !rx_evt && !tx_evt |=> !irq);
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/serial_front_ctl_tb.sv
module serial_front_ctl_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_err, tx_valid, tx_ready, rx_valid, rx_ready, irq;
  logic [7:0]  tx_data, rx_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [31:0] m_div, m_ctrl, m_dbg;
  logic        m_rxe, m_txe;
  logic [7:0]  m_rxb;

  always #4 clk = ~clk;

  serial_front_ctl u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a >> 2)
      0: return {24'h0, m_rxb};
      1: return m_div;
      2: return {29'h0, m_txe, m_rxe, 1'b1};
      3: return m_ctrl;
      4: return m_dbg;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return (m_ctrl[0] && m_rxe) || (m_ctrl[1] && m_txe);
  endfunction

  task automatic do_rd(input logic [7:0] a);
    bus_rd = 1'b1; bus_addr = a;
    step();
    bus_rd = 1'b0;
    chk(((a >> 2) > 4) ? "R11 read unimplemented" : "R10 read data", bus_rdata, exp_rd(a));
    chk("R11 err on read", {31'h0, bus_err}, {31'h0, ((a >> 2) > 4)});
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] v);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    step();
    bus_wr = 1'b0;
    case (a >> 2)
      0: begin
        m_txe = 1'b1;
        chk("R4 tx_valid after write", {31'h0, tx_valid}, 32'h1);
        chk("R4 tx_data", {24'h0, tx_data}, {24'h0, v[7:0]});
      end
      1: m_div = v;
      2: begin
        if (v[1]) m_rxe = 1'b0;
        if (v[2]) m_txe = 1'b0;
      end
      3: m_ctrl = v;
      4: m_dbg = v;
      default: ;
    endcase
    chk("R11 err on write", {31'h0, bus_err}, {31'h0, ((a >> 2) > 4)});
  endtask

  task automatic do_rx(input logic [7:0] b, input bit with_clr);
    chk("R5 rx_ready mirrors rx event", {31'h0, rx_ready}, {31'h0, !m_rxe});
    rx_valid = 1'b1; rx_data = b;
    if (with_clr) begin
      bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h2;
    end
    step();
    rx_valid = 1'b0; bus_wr = 1'b0;
    if (!m_rxe) begin
      m_rxe = 1'b1; m_rxb = b;
    end else if (with_clr) begin
      m_rxe = 1'b0;
    end
  endtask

  task automatic chk_irq(input string req);
    step();
    chk(req, {31'h0, irq}, {31'h0, exp_irq()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h1d5c_0a77));
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    tx_ready = 1'b1; rx_valid = 0; rx_data = 0;
    m_div = 0; m_ctrl = 0; m_dbg = 0; m_rxe = 0; m_txe = 0; m_rxb = 0;
    repeat (3) step();
    rst = 1'b0;
    step();

    // R1 reset state
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
    chk("R1 bus_err", {31'h0, bus_err}, 32'h0);
    chk("R1 rx_ready", {31'h0, rx_ready}, 32'h1);
    for (int i = 0; i < 5; i++) begin
      bus_rd = 1'b1; bus_addr = 8'(i * 4); step(); bus_rd = 1'b0;
      chk("R1 reset register", bus_rdata, (i == 2) ? 32'h1 : 32'h0);
    end

    // R2 low address bits ignored
    do_wr(8'h07, 32'hA5A5_1234);
    do_rd(8'h04);
    do_wr(8'h0E, 32'hFFFF_FFFC);
    do_rd(8'h0D);
    chk_irq("R3 control bit 2 stored only, irq stays low");
    do_wr(8'h13, 32'hDEAD_BEEF);
    do_rd(8'h10);

    // R11 unimplemented word: write ignored, reads zero
    do_wr(8'h14, 32'hFFFF_FFFF);
    step();
    chk("R11 err is one cycle", {31'h0, bus_err}, 32'h0);
    do_rd(8'h14);
    do_rd(8'h04);
    do_rd(8'h0C);

    // R4 back-pressure and replacement
    tx_ready = 1'b0;
    do_wr(8'h00, 32'h0000_01AB);
    repeat (3) step();
    chk("R4 held under back-pressure", {23'h0, tx_valid, tx_data}, {23'h0, 1'b1, 8'hAB});
    do_wr(8'h00, 32'h0000_00CD);
    step();
    chk("R4 replaced byte", {23'h0, tx_valid, tx_data}, {23'h0, 1'b1, 8'hCD});
    tx_ready = 1'b1;
    step();
    chk("R4 drained", {31'h0, tx_valid}, 32'h0);
    do_rd(8'h08);

    // R7 clear tx only; zero bits leave flags
    do_wr(8'h08, 32'h0);
    do_rd(8'h08);
    do_wr(8'h08, 32'hFFFF_FFFB);
    do_rd(8'h08);
    do_wr(8'h08, 32'h4);
    do_rd(8'h08);

    // R9 irq timing: set rx enable, capture a byte
    do_wr(8'h0C, 32'h1);
    do_rx(8'h5A, 0);
    chk("R9 irq lags flag by one cycle", {31'h0, irq}, 32'h0);
    step();
    chk("R9 irq after rx event", {31'h0, irq}, 32'h1);
    do_rd(8'h00);
    // R6 refused while event set
    do_rx(8'h77, 0);
    chk("R6 rx_ready low", {31'h0, rx_ready}, 32'h0);
    do_rd(8'h00);
    // R7 clear rx
    do_wr(8'h08, 32'h2);
    chk_irq("R9 irq falls after clear");
    // R8 capture and clear in same cycle
    do_rx(8'h3C, 1);
    do_rd(8'h08);
    do_rd(8'h00);
    do_wr(8'h08, 32'h6);

    // R10 read in same cycle as write returns old value
    bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h1111_2222;
    step();
    bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R10 read-before-write", bus_rdata, m_div);
    m_div = 32'h1111_2222;
    step();
    chk("R10 rdata held", bus_rdata, 32'hA5A5_1234);

    // random phase
    for (int k = 0; k < 500; k++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0: do_wr(8'($urandom_range(0, 4) * 4 + $urandom_range(0, 3)), $urandom());
        1: do_wr(8'h00, $urandom());
        2: do_wr(8'h08, {29'h0, 3'($urandom())});
        3: do_rd(8'($urandom_range(0, 255)));
        4: do_rx(8'($urandom()), bit'($urandom_range(0, 1)));
        default: do_wr(8'($urandom_range(5, 63) * 4), $urandom());
      endcase
      chk_irq("R9 irq random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule